// File: doc/BRIEF.md
# Early-Start Ethernet Transmit Framer

The framer accepts one Ethernet frame at a time from a host and sends it as a byte stream towards a MAC-side line interface. A frame begins with a transmit command that selects, for that frame only, how many bytes must be buffered before the line side starts, whether pad bytes are added to short frames and whether a frame check sequence is appended. The host then states the frame length. Once that length fits the internal buffer, the block raises a grant. From then on the host writes the frame bytes, one per cycle, whenever it has them.

The line side starts as soon as the buffered count reaches the chosen threshold. This means a long frame can be on the wire while the host is still loading it. The block sends a preamble and a start delimiter, then the stored bytes in write order, then optional zero padding and an optional CRC-32. If the line side reaches a byte the host has not yet supplied, the frame is cut short and a sticky underrun flag is raised.

Top module: `early_tx_framer`

## Requirements
- R1: A command (`cmd_valid`) is taken only while the block is idle. `cmd_thr_sel` encodes the start threshold: 0 = 5 bytes, 1 = 381 bytes, 2 = 1021 bytes, 3 = whole frame. `cmd_crc_en` and `cmd_pad_en` apply to that frame only. A command given while a frame is in progress has no effect on that frame.
- R2: After a command, a length on `len_bytes` with `len_valid` is taken only if it lies between 1 and DEPTH. `grant` goes high in the cycle after an accepted length. A zero or oversize length leaves `grant` low, and the block keeps waiting for a length.
- R3: A byte on `wr_data` with `wr_valid` is stored only while `grant` is high and fewer than the granted length have been stored. Writes made while `grant` is low are ignored.
- R4: The first output byte appears in the cycle after the clock edge at which the stored count reaches the smaller of the threshold and the frame length.
- R5: Every frame opens with seven bytes of 0x55 followed by one byte of 0xD5.
- R6: After the delimiter, the stored bytes are sent in the order they were written.
- R7: With padding on and a length below 60, zero bytes follow the data until 60 data-plus-pad bytes have been sent. With padding off, no pad bytes are sent.
- R8: With CRC on, four bytes follow the data and pad bytes. They hold the complemented CRC-32 (reflected polynomial 0xEDB88320, initial value all ones) over the data and pad bytes, least significant byte first. With CRC off, nothing follows the data and pad bytes.
- R9: Output bytes come one per cycle with `tx_valid` high and no gaps. `tx_last` marks the final byte, after which `tx_valid` and `grant` drop.
- R10: If the next data byte to send has not been written, the frame stops: no further bytes are sent, `tx_last` is not given, `grant` drops and `underrun` rises. `underrun` stays high until the next accepted command clears it.
- R11: After reset, `grant`, `tx_valid`, `tx_last` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Transmit command strobe |
| cmd_thr_sel | input | 2 | Start threshold code (R1) |
| cmd_crc_en | input | 1 | Append CRC for this frame |
| cmd_pad_en | input | 1 | Pad this frame if short |
| len_valid | input | 1 | Frame length strobe |
| len_bytes | input | LEN_W | Frame length in bytes, excluding CRC |
| grant | output | 1 | Buffer space reserved; frame bytes may be written |
| wr_valid | input | 1 | Frame byte strobe |
| wr_data | input | 8 | Frame byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| underrun | output | 1 | Sticky flag: frame aborted for lack of data |

## Verification
Frames are tried with every threshold code. Lengths are picked so that the threshold falls below, at and above the frame length, which separates an early start from a whole-frame start and shows the clamp to the length. The four settings of the pad and CRC flags are tried on short frames, and on lengths of 59 and 60 around the padding boundary, so that missing, surplus or misplaced pad and CRC bytes all change the compared stream. Directed runs cover a host that stops writing after the threshold, lengths that must be refused, writes made before the grant, and a command issued during a frame.

// File: rtl/etx_pkg.sv
package etx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLEN,
    ST_LOAD,
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_PAD,
    ST_FCS
  } etx_state_e;

  localparam int unsigned THR_SHORT = 5;
  localparam int unsigned THR_MID   = 381;
  localparam int unsigned THR_LONG  = 1021;

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam int unsigned PRE_LEN   = 7;
  localparam int unsigned MIN_BODY  = 60;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  // Advance a reflected CRC-32 by one byte, low bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h000000, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/etx_txbuf.sv
module etx_txbuf #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] wcount
);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wcount_q, wcount_n;

  always_comb begin
    wcount_n = wcount_q;
    if (clr) begin
      wcount_n = '0;
    end else if (wr_en) begin
      wcount_n = wcount_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcount_q <= '0;
    end else begin
      wcount_q <= wcount_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wcount_q[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
  assign wcount  = wcount_q;

endmodule

// File: rtl/etx_crc32.sv
module etx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        adv,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import etx_pkg::*;

  logic [31:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (init) begin
      crc_n = 32'hFFFFFFFF;
    end else if (adv) begin
      crc_n = crc32_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 32'hFFFFFFFF;
    end else begin
      crc_q <= crc_n;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/etx_ctrl.sv
module etx_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_thr_sel,
  input  logic          cmd_crc_en,
  input  logic          cmd_pad_en,
  input  logic          len_valid,
  input  logic [CW-1:0] len_bytes,
  input  logic          wr_valid,
  input  logic [CW-1:0] wcount,
  input  logic [7:0]    rd_data,
  input  logic [31:0]   crc,
  output logic          buf_clr,
  output logic          buf_wr,
  output logic [AW-1:0] rd_addr,
  output logic          crc_init,
  output logic          crc_adv,
  output logic [7:0]    crc_din,
  output logic          grant,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          underrun
);
  import etx_pkg::*;

  etx_state_e    st_q, st_n;
  logic [1:0]    sel_q, sel_n;
  logic          crc_en_q, crc_en_n;
  logic          pad_en_q, pad_en_n;
  logic [CW-1:0] len_q, len_n;
  logic [CW-1:0] pos_q, pos_n;
  logic [2:0]    idx_q, idx_n;
  logic          ur_q, ur_n;

  int unsigned   thr;
  logic          start_ok;
  logic          pad_need;
  logic          len_ok;

  // Effective start threshold, clamped to the frame length.
  always_comb begin
    case (sel_q)
      2'd0:    thr = THR_SHORT;
      2'd1:    thr = THR_MID;
      2'd2:    thr = THR_LONG;
      default: thr = 32'(len_q);
    endcase
    if (thr > 32'(len_q)) begin
      thr = 32'(len_q);
    end
  end

  assign start_ok = 32'(wcount) >= thr;
  assign pad_need = pad_en_q && (len_q < CW'(MIN_BODY));
  assign len_ok   = (len_bytes != '0) && (len_bytes <= CW'(DEPTH));
  assign grant    = (st_q != ST_IDLE) && (st_q != ST_WLEN);
  assign buf_wr   = wr_valid && grant && (wcount < len_q);
  assign rd_addr  = pos_q[AW-1:0];
  assign underrun = ur_q;

  always_comb begin
    st_n     = st_q;
    sel_n    = sel_q;
    crc_en_n = crc_en_q;
    pad_en_n = pad_en_q;
    len_n    = len_q;
    pos_n    = pos_q;
    idx_n    = idx_q;
    ur_n     = ur_q;
    buf_clr  = 1'b0;
    crc_init = 1'b0;
    crc_adv  = 1'b0;
    crc_din  = 8'h00;
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    tx_last  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          sel_n    = cmd_thr_sel;
          crc_en_n = cmd_crc_en;
          pad_en_n = cmd_pad_en;
          ur_n     = 1'b0;
          buf_clr  = 1'b1;
          st_n     = ST_WLEN;
        end
      end
      ST_WLEN: begin
        if (len_valid && len_ok) begin
          len_n = len_bytes;
          st_n  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (start_ok) begin
          idx_n    = '0;
          crc_init = 1'b1;
          st_n     = ST_PRE;
        end
      end
      ST_PRE: begin
        tx_valid = 1'b1;
        tx_data  = PRE_BYTE;
        idx_n    = idx_q + 1'b1;
        if (idx_q == 3'(PRE_LEN - 1)) begin
          st_n = ST_SFD;
        end
      end
      ST_SFD: begin
        tx_valid = 1'b1;
        tx_data  = SFD_BYTE;
        pos_n    = '0;
        st_n     = ST_BODY;
      end
      ST_BODY: begin
        if (pos_q >= wcount) begin
          ur_n = 1'b1;
          st_n = ST_IDLE;
        end else begin
          tx_valid = 1'b1;
          tx_data  = rd_data;
          crc_adv  = 1'b1;
          crc_din  = rd_data;
          pos_n    = pos_q + 1'b1;
          if (pos_q == len_q - 1'b1) begin
            if (pad_need) begin
              st_n = ST_PAD;
            end else if (crc_en_q) begin
              idx_n = '0;
              st_n  = ST_FCS;
            end else begin
              tx_last = 1'b1;
              st_n    = ST_IDLE;
            end
          end
        end
      end
      ST_PAD: begin
        tx_valid = 1'b1;
        tx_data  = 8'h00;
        crc_adv  = 1'b1;
        crc_din  = 8'h00;
        pos_n    = pos_q + 1'b1;
        if (pos_q == CW'(MIN_BODY - 1)) begin
          if (crc_en_q) begin
            idx_n = '0;
            st_n  = ST_FCS;
          end else begin
            tx_last = 1'b1;
            st_n    = ST_IDLE;
          end
        end
      end
      ST_FCS: begin
        tx_valid = 1'b1;
        tx_data  = ~crc[{idx_q[1:0], 3'b000} +: 8];
        idx_n    = idx_q + 1'b1;
        if (idx_q == 3'd3) begin
          tx_last = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sel_q    <= 2'd0;
      crc_en_q <= 1'b0;
      pad_en_q <= 1'b0;
      len_q    <= '0;
      pos_q    <= '0;
      idx_q    <= '0;
      ur_q     <= 1'b0;
    end else begin
      st_q     <= st_n;
      sel_q    <= sel_n;
      crc_en_q <= crc_en_n;
      pad_en_q <= pad_en_n;
      len_q    <= len_n;
      pos_q    <= pos_n;
      idx_q    <= idx_n;
      ur_q     <= ur_n;
    end
  end

endmodule

// File: rtl/early_tx_framer.sv
module early_tx_framer #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_thr_sel,
  input  logic             cmd_crc_en,
  input  logic             cmd_pad_en,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_bytes,
  output logic             grant,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             underrun
);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             buf_clr;
  logic             buf_wr;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;
  logic [LEN_W-1:0] wcount;
  logic             crc_init;
  logic             crc_adv;
  logic [7:0]       crc_din;
  logic [31:0]      crc;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  etx_txbuf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (buf_clr),
    .wr_en   (buf_wr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wcount  (wcount)
  );

  etx_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .init  (crc_init),
    .adv   (crc_adv),
    .din   (crc_din),
    .crc   (crc)
  );

  etx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_valid   (cmd_valid),
    .cmd_thr_sel (cmd_thr_sel),
    .cmd_crc_en  (cmd_crc_en),
    .cmd_pad_en  (cmd_pad_en),
    .len_valid   (len_valid),
    .len_bytes   (len_bytes),
    .wr_valid    (wr_valid),
    .wcount      (wcount),
    .rd_data     (rd_data),
    .crc         (crc),
    .buf_clr     (buf_clr),
    .buf_wr      (buf_wr),
    .rd_addr     (rd_addr),
    .crc_init    (crc_init),
    .crc_adv     (crc_adv),
    .crc_din     (crc_din),
    .grant       (grant),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .underrun    (underrun)
  );

endmodule

// File: rtl/etx_checker.sv
module etx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       len_valid,
  input logic       grant,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       underrun
);

  // R9: the end marker only rides on a valid byte
  assert_last_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R9: after the end marker the stream and the grant fall
  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> (!tx_valid && !grant));

  // R5: every frame opens with a preamble byte
  assert_opens_with_preamble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == 8'h55));

  // R2: grant only follows a length strobe
  assert_grant_needs_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(len_valid));

  // R10: an underrun leaves the line quiet and the grant withdrawn
  assert_underrun_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (!tx_valid && !grant));

endmodule

bind early_tx_framer etx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .len_valid (len_valid),
  .grant     (grant),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .underrun  (underrun)
);

// File: tb/early_tx_framer_test.sv
module early_tx_framer_test;

  localparam int unsigned DEPTH = 2048;
  localparam int unsigned LW    = 12;
  localparam time CLK_PERIOD    = 10ns;
  localparam int NVEC           = 10;

  // {thr_sel, crc_en, pad_en, length, seed, expected output byte count}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd3, 1'b1, 1'b1, 12'd64,   8'd11,  12'd76},
    {2'd0, 1'b1, 1'b1, 12'd20,   8'd23,  12'd72},
    {2'd0, 1'b0, 1'b1, 12'd20,   8'd37,  12'd68},
    {2'd0, 1'b1, 1'b0, 12'd20,   8'd41,  12'd32},
    {2'd1, 1'b1, 1'b1, 12'd64,   8'd53,  12'd76},
    {2'd1, 1'b1, 1'b0, 12'd500,  8'd67,  12'd512},
    {2'd2, 1'b1, 1'b0, 12'd1100, 8'd79,  12'd1112},
    {2'd0, 1'b0, 1'b0, 12'd1,    8'd83,  12'd9},
    {2'd3, 1'b1, 1'b1, 12'd59,   8'd97,  12'd72},
    {2'd3, 1'b1, 1'b1, 12'd60,   8'd101, 12'd72}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_thr_sel;
  logic          cmd_crc_en;
  logic          cmd_pad_en;
  logic          len_valid;
  logic [LW-1:0] len_bytes;
  logic          grant;
  logic          wr_valid;
  logic [7:0]    wr_data;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_last;
  logic          underrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] got [2048];
  logic [7:0] expv [2048];
  int got_n, exp_n, last_idx, first_v, thr_edge;

  early_tx_framer #(.DEPTH(DEPTH)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_thr_sel (cmd_thr_sel),
    .cmd_crc_en  (cmd_crc_en),
    .cmd_pad_en  (cmd_pad_en),
    .len_valid   (len_valid),
    .len_bytes   (len_bytes),
    .grant       (grant),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .underrun    (underrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expd);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed + i * 13) ^ (i >> 5));
  endfunction

  // Bit-serial reference CRC: one data bit per step.
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic build_exp(input int crc, input int pad, input int len, input int seed);
    logic [31:0] c;
    int body;
    c = 32'hFFFFFFFF;
    exp_n = 0;
    for (int i = 0; i < 7; i++) begin expv[exp_n] = 8'h55; exp_n++; end
    expv[exp_n] = 8'hD5; exp_n++;
    body = (pad != 0 && len < 60) ? 60 : len;
    for (int i = 0; i < body; i++) begin
      expv[exp_n] = (i < len) ? dbyte(seed, i) : 8'h00;
      c = ref_crc(c, expv[exp_n]);
      exp_n++;
    end
    if (crc != 0) begin
      for (int k = 0; k < 4; k++) begin
        expv[exp_n] = ~c[8*k +: 8];
        exp_n++;
      end
    end
  endtask

  // mode 1: refused lengths and early writes first; mode 2: command mid-frame
  task automatic run_frame(input int sel, input int crc, input int pad, input int len,
                           input int seed, input int stop_after, input int mode);
    int eff;
    eff = (sel == 0) ? 5 : (sel == 1) ? 381 : (sel == 2) ? 1021 : len;
    if (eff > len) eff = len;
    got_n = 0; last_idx = -1; first_v = -1; thr_edge = -1;
    fork
      begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_thr_sel = 2'(sel); cmd_crc_en = crc[0]; cmd_pad_en = pad[0];
        @(negedge clk);
        cmd_valid = 1'b0;
        if (mode == 1) begin
          len_valid = 1'b1; len_bytes = LW'(DEPTH + 1);
          wr_valid = 1'b1; wr_data = 8'hEE;
          @(negedge clk);
          chk(grant == 1'b0, "R2 oversize length refused", int'(grant), 0);
          len_bytes = '0;
          @(negedge clk);
          chk(grant == 1'b0, "R2 zero length refused", int'(grant), 0);
          len_valid = 1'b0; wr_valid = 1'b0;
        end
        len_valid = 1'b1; len_bytes = LW'(len);
        @(negedge clk);
        len_valid = 1'b0;
        while (!grant) @(negedge clk);
        for (int i = 0; i < len && i < stop_after; i++) begin
          wr_valid = 1'b1; wr_data = dbyte(seed, i);
          if (mode == 2 && i == 3) begin
            cmd_valid = 1'b1; cmd_thr_sel = 2'd3;
            cmd_crc_en = ~crc[0]; cmd_pad_en = ~pad[0];
          end
          if (i + 1 == eff) thr_edge = cyc + 1;
          @(negedge clk);
          cmd_valid = 1'b0;
        end
        wr_valid = 1'b0;
      end
      begin
        @(negedge clk);
        @(posedge clk);
        for (int k = 0; k < 4000; k++) begin
          @(posedge clk); #1;
          if (tx_valid) begin
            if (first_v < 0) first_v = cyc;
            got[got_n] = tx_data;
            if (tx_last) last_idx = got_n;
            got_n++;
          end
          if (tx_last || underrun) break;
        end
      end
    join
    @(negedge clk);
  endtask

  task automatic check_stream(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (bad < 0 && got[i] !== expv[i]) bad = i;
    end
    if (bad >= 0)
      chk(1'b0, {tag, " R5/R6/R7/R8 byte content"}, int'(got[bad]), int'(expv[bad]));
    else
      chk(1'b1, tag, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_thr_sel = 2'd0; cmd_crc_en = 1'b0;
    cmd_pad_en = 1'b0; len_valid = 1'b0; len_bytes = '0; wr_valid = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R11: quiet outputs while in reset
    chk(!grant && !tx_valid && !tx_last && !underrun, "R11 reset outputs",
        int'({grant, tx_valid, tx_last, underrun}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!grant && !tx_valid && !underrun, "R11 after release",
        int'({grant, tx_valid, underrun}), 0);

    // Table walk: R1 threshold codes, R4 start cycle, R5-R9 stream shape
    for (int v = 0; v < NVEC; v++) begin
      int sel, crc, pad, len, seed, tot;
      sel  = int'(VEC[v][35:34]);
      crc  = int'(VEC[v][33]);
      pad  = int'(VEC[v][32]);
      len  = int'(VEC[v][31:20]);
      seed = int'(VEC[v][19:12]);
      tot  = int'(VEC[v][11:0]);
      build_exp(crc, pad, len, seed);
      run_frame(sel, crc, pad, len, seed, 100000, 0);
      chk(got_n == tot, $sformatf("R7/R8/R9 vector %0d byte count", v), got_n, tot);
      check_stream($sformatf("vector %0d", v));
      chk(last_idx == tot - 1, $sformatf("R9 vector %0d end marker position", v), last_idx, tot - 1);
      chk(first_v == thr_edge + 1, $sformatf("R4 R1 vector %0d start cycle", v), first_v, thr_edge + 1);
    end

    // R2 and R3: refused lengths with writes before the grant
    build_exp(1, 1, 30, 7);
    run_frame(0, 1, 1, 30, 7, 100000, 1);
    chk(got_n == exp_n, "R3 early writes ignored, byte count", got_n, exp_n);
    check_stream("R3 early writes ignored");

    // R1: a command during a frame does not change it
    build_exp(1, 0, 40, 9);
    run_frame(0, 1, 0, 40, 9, 100000, 2);
    chk(got_n == exp_n, "R1 mid-frame command ignored, byte count", got_n, exp_n);
    check_stream("R1 mid-frame command ignored");

    // R10: host stops after five bytes with a five-byte threshold
    build_exp(1, 0, 100, 5);
    run_frame(0, 1, 0, 100, 5, 5, 0);
    chk(got_n == 13, "R10 bytes sent before abort", got_n, 13);
    check_stream("R10 partial stream");
    chk(last_idx == -1, "R10 no end marker", last_idx, -1);
    chk(underrun == 1'b1, "R10 underrun raised", int'(underrun), 1);
    repeat (3) @(negedge clk);
    chk(underrun == 1'b1 && !tx_valid, "R10 underrun held", int'(underrun), 1);

    // R10: next accepted command clears the flag and the frame runs normally
    build_exp(1, 1, 16, 3);
    run_frame(3, 1, 1, 16, 3, 100000, 0);
    chk(underrun == 1'b0, "R10 flag cleared by command", int'(underrun), 0);
    chk(got_n == exp_n && last_idx == exp_n - 1, "R9 frame after underrun", got_n, exp_n);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule